// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits behind the clock synthesizer of a multi-output clock generator and decides which derived clocks reach the pins. It receives a fast processor-domain clock, a bus clock running at half that rate and a reference-rate clock. From these it drives a bank of gateable processor clocks, a bank of gateable bus clocks and one bus clock that is never gated. Two package pins are shared. After an asynchronous power-on reset a mode strap is sampled once. A low strap selects power-management operation, and the two shared pins then become active-low stop requests, one for the processor clocks and one for the bus clocks. A high strap turns the same pins into extra clock outputs: the reference-rate clock and an ungated bus clock. In that mode both stop functions are disabled.

Each stop request passes through a two-flop synchronizer in the domain of the clock it controls. It then drives a small per-domain state machine with three states. `STOP_RUN` means the clock is delivered. `STOP_HALT` means the clock is parked low. `STOP_WAIT` counts a minimum number of cycles after the request is released and only then allows the clock again. The RUN/HALT/WAIT result is retimed on the falling edge of the gated clock and ANDed with it, so an output can only start or stop while its clock is low. Every restarted cycle therefore begins with a full high phase.

The mode state machine has three states. `MODE_SAMPLE` is entered at reset and lasts for exactly one processor-clock edge, on which the strap is read. It then moves to `MODE_PWRMGT` if the strap is low or to `MODE_CLKOUT` if the strap is high. Both of those states are terminal until the next reset. The transitions of the stop machine are as follows. RUN goes to HALT when a request is seen. HALT goes to WAIT when the request is released, and the counter is cleared. WAIT goes back to HALT if the request returns. WAIT goes to RUN once the count reaches the resume minimum.

Top module: `clk_stop_ctrl`

## Requirements
- R1: The mode strap is read on the first rising `cpu_clk` edge after `por_n` rises. Low selects power-management mode, in which `cpu_stop_pin_oe` and `bus_stop_pin_oe` are 0. High selects clock-output mode, in which both are 1. Later strap changes have no effect until the next reset.
- R2: In clock-output mode, `cpu_stop_pin_out` follows `ref_clk` and `bus_stop_pin_out` follows `bus_clk`. Both pin inputs are ignored, so all gated outputs keep running even when the pins are low.
- R3: In power-management mode, a low level (active) on `cpu_stop_pin_in` parks every `cpu_clk_out` bit at 0. Counting `cpu_clk` rising edges after the pin falls, the last high pulse comes on edge 3 and the outputs are low from edge 4 onward.
- R4: In power-management mode, a low level on `bus_stop_pin_in` parks every `bus_clk_out` bit at 0. Counting `bus_clk` rising edges after the pin falls, the last high pulse comes on edge 3 and the outputs are low from edge 4 onward.
- R5: The two stops are independent. A processor stop leaves the bus outputs running, a bus stop leaves the processor outputs running, and both low stops both banks.
- R6: `bus_clk_free` follows `bus_clk` at all times after reset, whatever the stop pins and the mode.
- R7: After `cpu_stop_pin_in` rises, the processor outputs stay low until `cpu_clk` rising edge 4+CPU_RESUME and are high on that edge. The gap is at least CPU_RESUME cycles.
- R8: After `bus_stop_pin_in` rises, the bus outputs stay low until `bus_clk` rising edge 4+BUS_RESUME and are high on that edge.
- R9: Gated outputs change state only while their source clock is low. The first pulse after a restart is high for the whole high phase of the source clock.
- R10: A stop request that returns during the resume wait keeps the outputs low. A later release restarts the full resume count.
- R11: While `por_n` is low, all gated outputs, both pin outputs and both pin enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Fast processor-domain source clock |
| bus_clk | input | 1 | Half-rate bus source clock |
| ref_clk | input | 1 | Reference-rate clock for the shared pin |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| mode_strap | input | 1 | Mode strap, sampled once after reset |
| cpu_stop_pin_in | input | 1 | Shared pin input: active-low processor stop |
| bus_stop_pin_in | input | 1 | Shared pin input: active-low bus stop |
| cpu_clk_out | output | NUM_CPU | Gated processor clocks |
| bus_clk_out | output | NUM_BUS | Gated bus clocks |
| bus_clk_free | output | 1 | Ungated bus clock |
| cpu_stop_pin_out | output | 1 | Shared pin output: reference-rate clock |
| cpu_stop_pin_oe | output | 1 | Output enable of the processor-stop pin |
| bus_stop_pin_out | output | 1 | Shared pin output: extra bus clock |
| bus_stop_pin_oe | output | 1 | Output enable of the bus-stop pin |

## Verification
The bench builds the block with NUM_CPU=3, NUM_BUS=2, CPU_RESUME=3 and BUS_RESUME=2. A bus resume of 2 exercises the counting path of the wait state in the bus domain, not just a single pass through it. A processor resume of 3 leaves a window wide enough to re-raise the stop while WAIT is still counting, which is how the R10 restart is reached. Two banks of several outputs show that every replicated gate follows its domain's state machine.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        STOP_RUN  = 2'd0,
        STOP_HALT = 2'd1,
        STOP_WAIT = 2'd2
    } stop_state_e;

    typedef enum logic [1:0] {
        MODE_SAMPLE = 2'd0,
        MODE_PWRMGT = 2'd1,
        MODE_CLKOUT = 2'd2
    } mode_state_e;

endpackage

// File: rtl/csc_sync2.sv
module csc_sync2 #(
    parameter int         WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/csc_clk_gate.sv
module csc_clk_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en,
    output logic clk_out
);

    logic en_low_q;

    // Enable is captured while the clock is low, so the AND never cuts a high phase.
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) en_low_q <= 1'b0;
        else        en_low_q <= en;
    end

    assign clk_out = clk_in & en_low_q;

endmodule

// File: rtl/csc_mode_fsm.sv
module csc_mode_fsm
    import csc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    output logic pm_mode,
    output logic clkout_mode
);

    mode_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SAMPLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SAMPLE: state_d = strap ? MODE_CLKOUT : MODE_PWRMGT;
            MODE_PWRMGT: state_d = MODE_PWRMGT;
            MODE_CLKOUT: state_d = MODE_CLKOUT;
            default:     state_d = MODE_SAMPLE;
        endcase
    end

    always_comb begin
        pm_mode     = 1'b0;
        clkout_mode = 1'b0;
        unique case (state_q)
            MODE_SAMPLE: ;
            MODE_PWRMGT: pm_mode     = 1'b1;
            MODE_CLKOUT: clkout_mode = 1'b1;
            default:     ;
        endcase
    end

    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_SAMPLE) |=> $stable(state_q));

    assert_sample_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_SAMPLE) |=> (state_q != MODE_SAMPLE));

    assert_modes_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_mode && clkout_mode));

endmodule

// File: rtl/csc_stop_fsm.sv
module csc_stop_fsm
    import csc_pkg::*;
#(
    parameter int MIN_RESUME = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    output logic run_en
);

    localparam int CNT_W = (MIN_RESUME < 1) ? 1 : $clog2(MIN_RESUME + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_RESUME - 1);
    localparam logic [CNT_W-1:0] MIN_CNT  = CNT_W'(MIN_RESUME);

    stop_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STOP_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STOP_RUN: begin
                if (stop_req) state_d = STOP_HALT;
            end
            STOP_HALT: begin
                if (!stop_req) begin
                    state_d = STOP_WAIT;
                    cnt_d   = '0;
                end
            end
            STOP_WAIT: begin
                if (stop_req)               state_d = STOP_HALT;
                else if (cnt_q == LAST_CNT) state_d = STOP_RUN;
                else                        cnt_d   = cnt_q + CNT_W'(1);
            end
            default: state_d = STOP_RUN;
        endcase
    end

    always_comb begin
        run_en = 1'b0;
        unique case (state_q)
            STOP_RUN:  run_en = 1'b1;
            STOP_HALT: run_en = 1'b0;
            STOP_WAIT: run_en = 1'b0;
            default:   run_en = 1'b0;
        endcase
    end

    // Independent count of released cycles, used only to judge the resume gap.
    logic [CNT_W-1:0] rel_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rel_cnt_q <= MIN_CNT;
        else if (stop_req)           rel_cnt_q <= '0;
        else if (rel_cnt_q != MIN_CNT) rel_cnt_q <= rel_cnt_q + CNT_W'(1);
    end

    // Shared by both domains: R7 for the processor instance, R8 for the bus instance.
    assert_resume_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != STOP_RUN && state_q == STOP_RUN) |-> (rel_cnt_q >= MIN_CNT));

    assert_halt_on_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != STOP_HALT && state_q == STOP_HALT) |-> $past(stop_req));

    assert_rearm_in_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == STOP_WAIT && stop_req) |=> (state_q == STOP_HALT));

    assert_run_needs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == STOP_RUN && !stop_req) |=> (state_q == STOP_RUN));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
    parameter int NUM_CPU    = 5,
    parameter int NUM_BUS    = 6,
    parameter int CPU_RESUME = 3,
    parameter int BUS_RESUME = 1
) (
    input  logic               cpu_clk,
    input  logic               bus_clk,
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic               mode_strap,
    input  logic               cpu_stop_pin_in,
    input  logic               bus_stop_pin_in,
    output logic [NUM_CPU-1:0] cpu_clk_out,
    output logic [NUM_BUS-1:0] bus_clk_out,
    output logic               bus_clk_free,
    output logic               cpu_stop_pin_out,
    output logic               cpu_stop_pin_oe,
    output logic               bus_stop_pin_out,
    output logic               bus_stop_pin_oe
);

    localparam int BUS_SYNC_W = 3;
    localparam logic [BUS_SYNC_W-1:0] BUS_SYNC_RST = 3'b001;

    logic pm_cpu, clkout_cpu;
    logic cpu_pin_s, cpu_req, cpu_run;
    logic [BUS_SYNC_W-1:0] bus_sync_q;
    logic pm_bus, clkout_bus, bus_pin_s, bus_req, bus_run;
    logic clkout_ref;

    csc_mode_fsm u_mode (
        .clk         (cpu_clk),
        .rst_n       (por_n),
        .strap       (mode_strap),
        .pm_mode     (pm_cpu),
        .clkout_mode (clkout_cpu)
    );

    // Processor domain
    csc_sync2 #(.WIDTH(1), .RST_VAL(1'b1)) u_cpu_sync (
        .clk   (cpu_clk),
        .rst_n (por_n),
        .d     (cpu_stop_pin_in),
        .q     (cpu_pin_s)
    );

    assign cpu_req = pm_cpu & ~cpu_pin_s;

    csc_stop_fsm #(.MIN_RESUME(CPU_RESUME)) u_cpu_fsm (
        .clk      (cpu_clk),
        .rst_n    (por_n),
        .stop_req (cpu_req),
        .run_en   (cpu_run)
    );

    for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_cpu_gate
        csc_clk_gate u_gate (
            .clk_in  (cpu_clk),
            .rst_n   (por_n),
            .en      (cpu_run),
            .clk_out (cpu_clk_out[gi])
        );
    end

    // Bus domain: mode bits and stop pin are resynchronized together.
    csc_sync2 #(.WIDTH(BUS_SYNC_W), .RST_VAL(BUS_SYNC_RST)) u_bus_sync (
        .clk   (bus_clk),
        .rst_n (por_n),
        .d     ({clkout_cpu, pm_cpu, bus_stop_pin_in}),
        .q     (bus_sync_q)
    );

    assign clkout_bus = bus_sync_q[2];
    assign pm_bus     = bus_sync_q[1];
    assign bus_pin_s  = bus_sync_q[0];
    assign bus_req    = pm_bus & ~bus_pin_s;

    csc_stop_fsm #(.MIN_RESUME(BUS_RESUME)) u_bus_fsm (
        .clk      (bus_clk),
        .rst_n    (por_n),
        .stop_req (bus_req),
        .run_en   (bus_run)
    );

    for (genvar gj = 0; gj < NUM_BUS; gj++) begin : g_bus_gate
        csc_clk_gate u_gate (
            .clk_in  (bus_clk),
            .rst_n   (por_n),
            .en      (bus_run),
            .clk_out (bus_clk_out[gj])
        );
    end

    assign bus_clk_free = bus_clk;

    // Shared pins in clock-output mode
    csc_clk_gate u_pin_b_gate (
        .clk_in  (bus_clk),
        .rst_n   (por_n),
        .en      (clkout_bus),
        .clk_out (bus_stop_pin_out)
    );

    csc_sync2 #(.WIDTH(1), .RST_VAL(1'b0)) u_ref_sync (
        .clk   (ref_clk),
        .rst_n (por_n),
        .d     (clkout_cpu),
        .q     (clkout_ref)
    );

    csc_clk_gate u_pin_a_gate (
        .clk_in  (ref_clk),
        .rst_n   (por_n),
        .en      (clkout_ref),
        .clk_out (cpu_stop_pin_out)
    );

    assign cpu_stop_pin_oe = clkout_cpu;
    assign bus_stop_pin_oe = clkout_cpu;

    assert_no_stop_in_clkout_R2: assert property (@(posedge cpu_clk) disable iff (!por_n)
        clkout_cpu |-> cpu_run);

    assert_bus_runs_in_clkout_R2: assert property (@(posedge bus_clk) disable iff (!por_n)
        clkout_bus |-> bus_run);

endmodule

// File: tb/clk_stop_ctrl_test.sv
`timescale 1ns/1ps
module clk_stop_ctrl_test;

    localparam int NC = 3;
    localparam int NB = 2;
    localparam int CR = 3;
    localparam int BR = 2;

    logic cpu_clk = 1'b0;
    logic bus_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic por_n = 1'b0;
    logic mode_strap = 1'b0;
    logic cpu_pin = 1'b1;
    logic bus_pin = 1'b1;
    logic [NC-1:0] cpu_out;
    logic [NB-1:0] bus_out;
    logic bus_free, pa_out, pa_oe, pb_out, pb_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [NC-1:0] C_ON = '1;
    localparam logic [NB-1:0] B_ON = '1;

    always #4 cpu_clk = ~cpu_clk;
    always @(posedge cpu_clk) bus_clk <= ~bus_clk;
    always #37 ref_clk = ~ref_clk;

    clk_stop_ctrl #(.NUM_CPU(NC), .NUM_BUS(NB), .CPU_RESUME(CR), .BUS_RESUME(BR)) uut (
        .cpu_clk          (cpu_clk),
        .bus_clk          (bus_clk),
        .ref_clk          (ref_clk),
        .por_n            (por_n),
        .mode_strap       (mode_strap),
        .cpu_stop_pin_in  (cpu_pin),
        .bus_stop_pin_in  (bus_pin),
        .cpu_clk_out      (cpu_out),
        .bus_clk_out      (bus_out),
        .bus_clk_free     (bus_free),
        .cpu_stop_pin_out (pa_out),
        .cpu_stop_pin_oe  (pa_oe),
        .bus_stop_pin_out (pb_out),
        .bus_stop_pin_oe  (pb_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cpu_edge(input int n);
        for (int i = 0; i < n; i++) @(posedge cpu_clk);
        #1;
    endtask

    task automatic bus_edge(input int n);
        for (int i = 0; i < n; i++) @(posedge bus_clk);
        #1;
    endtask

    task automatic apply_reset(input logic strap);
        por_n = 1'b0;
        mode_strap = strap;
        cpu_edge(5);
        chk("R11 cpu out in reset", 32'(cpu_out), 0);
        chk("R11 bus out in reset", 32'(bus_out), 0);
        chk("R11 pin oe in reset", {30'd0, pa_oe, pb_oe}, 0);
        chk("R11 pin out in reset", {30'd0, pa_out, pb_out}, 0);
        @(negedge cpu_clk); #1;
        por_n = 1'b1;
        cpu_edge(40);
    endtask

    task automatic test_pm_entry();
        apply_reset(1'b0);
        chk("R1 pm oe low", {30'd0, pa_oe, pb_oe}, 0);
        cpu_edge(1);
        chk("R1 cpu runs in pm", 32'(cpu_out), 32'(C_ON));
        bus_edge(1);
        chk("R1 bus runs in pm", 32'(bus_out), 32'(B_ON));
    endtask

    task automatic test_cpu_stop();
        logic ok;
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b0;
        cpu_edge(3);
        chk("R3 last pulse edge 3", 32'(cpu_out), 32'(C_ON));
        cpu_edge(1);
        chk("R3 low edge 4", 32'(cpu_out), 0);
        ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cpu_edge(1);
            if (cpu_out !== '0) ok = 1'b0;
        end
        chk("R3 stays low", 32'(ok), 1);
        bus_edge(1);
        chk("R5 bus runs during cpu stop", 32'(bus_out), 32'(B_ON));
        chk("R6 free bus clock", 32'(bus_free), 1);
        // release and measure the restart edge
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b1;
        ok = 1'b1;
        for (int k = 1; k < 4 + CR; k++) begin
            cpu_edge(1);
            if (cpu_out !== '0) ok = 1'b0;
        end
        chk("R7 low before resume", 32'(ok), 1);
        cpu_edge(1);
        chk("R7 high at edge 4+CPU_RESUME", 32'(cpu_out), 32'(C_ON));
        #2;
        chk("R9 full first high phase", 32'(cpu_out), 32'(C_ON));
    endtask

    task automatic test_cpu_rearm();
        logic ok;
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b0;
        cpu_edge(8);
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b1;
        cpu_edge(2);
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            cpu_edge(1);
            if (cpu_out !== '0) ok = 1'b0;
        end
        chk("R10 re-raised stop holds low", 32'(ok), 1);
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b1;
        ok = 1'b1;
        for (int k = 1; k < 4 + CR; k++) begin
            cpu_edge(1);
            if (cpu_out !== '0) ok = 1'b0;
        end
        chk("R10 full count restarted", 32'(ok), 1);
        cpu_edge(1);
        chk("R10 resumes after restart", 32'(cpu_out), 32'(C_ON));
    endtask

    task automatic test_bus_stop();
        logic ok;
        @(negedge bus_clk); #1;
        bus_pin = 1'b0;
        bus_edge(3);
        chk("R4 last pulse edge 3", 32'(bus_out), 32'(B_ON));
        bus_edge(1);
        chk("R4 low edge 4", 32'(bus_out), 0);
        bus_edge(3);
        chk("R4 stays low", 32'(bus_out), 0);
        chk("R6 free runs during bus stop", 32'(bus_free), 1);
        cpu_edge(1);
        chk("R5 cpu runs during bus stop", 32'(cpu_out), 32'(C_ON));
        @(negedge bus_clk); #1;
        bus_pin = 1'b1;
        ok = 1'b1;
        for (int k = 1; k < 4 + BR; k++) begin
            bus_edge(1);
            if (bus_out !== '0) ok = 1'b0;
        end
        chk("R8 low before resume", 32'(ok), 1);
        bus_edge(1);
        chk("R8 high at edge 4+BUS_RESUME", 32'(bus_out), 32'(B_ON));
        #5;
        chk("R9 full first bus high phase", 32'(bus_out), 32'(B_ON));
    endtask

    task automatic test_both_stop();
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b0;
        bus_pin = 1'b0;
        cpu_edge(12);
        chk("R5 both: cpu low", 32'(cpu_out), 0);
        bus_edge(1);
        chk("R5 both: bus low", 32'(bus_out), 0);
        chk("R6 free in both stop", 32'(bus_free), 1);
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b1;
        bus_pin = 1'b1;
        cpu_edge(20);
    endtask

    task automatic test_clkout_mode();
        apply_reset(1'b1);
        chk("R1 clkout oe high", {30'd0, pa_oe, pb_oe}, 3);
        @(negedge cpu_clk); #1;
        cpu_pin = 1'b0;
        bus_pin = 1'b0;
        mode_strap = 1'b0;
        cpu_edge(20);
        chk("R2 cpu ignores pin", 32'(cpu_out), 32'(C_ON));
        chk("R1 strap change ignored", {30'd0, pa_oe, pb_oe}, 3);
        bus_edge(1);
        chk("R2 bus ignores pin", 32'(bus_out), 32'(B_ON));
        chk("R2 pin b high with bus", 32'(pb_out), 1);
        @(negedge bus_clk); #1;
        chk("R2 pin b low with bus", 32'(pb_out), 0);
        #400;
        @(posedge ref_clk); #1;
        chk("R2 pin a high with ref", 32'(pa_out), 1);
        @(negedge ref_clk); #1;
        chk("R2 pin a low with ref", 32'(pa_out), 0);
        cpu_pin = 1'b1;
        bus_pin = 1'b1;
    endtask

    initial begin
        test_pm_entry();
        test_cpu_stop();
        test_cpu_rearm();
        test_bus_stop();
        test_both_stop();
        test_clkout_mode();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule